// File: doc/BRIEF.md
# Store-and-Forward Receive Queue with Non-Posted Bypass

This block sits between the receive side of a transaction layer and user logic. Incoming packets arrive as beats with a class tag (posted, non-posted or completion), a vector of base-address-window hits and a poison marker. Each packet is written into one of two packet queues: one for non-posted requests and one shared by posted writes and completions. Only after a packet's last beat has been written is it offered to user logic. It is offered on an active-low framed stream with start, end, remainder, source-ready, destination-ready and source-discontinue strobes.

An arbiter picks a new packet only between packets. While the user's non-posted-ok input is asserted, the packet whose last beat arrived first is served. While it is deasserted, only the posted/completion queue is served, so writes and completions overtake stalled requests. User logic deasserts non-posted-ok one cycle before the end beat of the last request it can accept. A link-down input aborts the packet currently on the stream, discards it and pulses the discontinue strobe.

Top module: `rxq_np_bypass`

## Requirements
- R1: A packet's start-of-frame and source-ready are first asserted no earlier than the second clock edge after its end beat is accepted at the input. Start-of-frame is low only together with source-ready.
- R2: A beat transfers on a rising edge only when source-ready and destination-ready are both low. While destination-ready is high, the presented beat, its framing and source-ready hold unchanged.
- R3: Packets of the same queue leave in the order their end beats arrived.
- R4: Class code 2'b01 is non-posted; codes 2'b00, 2'b10 and 2'b11 go to the posted/completion queue. With non-posted-ok low (asserted), the pending packet whose end beat arrived earliest is served next.
- R5: With non-posted-ok high, no non-posted packet is started. Posted/completion packets are still served. If only non-posted packets are pending, source-ready stays high.
- R6: On the end beat the remainder is 8'h00 when all 64 data bits are valid and 8'h0F when only bits [63:32] are valid (input half flag set). On other beats it is 8'h00.
- R7: The error-forward output is low only on the end beat of a packet received with its poison input set.
- R8: The 7-bit window-hit output is the bitwise inverse of the hit vector given on the packet's first input beat. Bits 0 to 5 are base windows 0 to 5 and bit 6 is the expansion ROM; a 64-bit window pair shows both bits low. The value is held for the whole packet and is all ones between packets.
- R9: After reset, and whenever nothing is pending, source-ready, start, end, error-forward and discontinue are high, the window-hit output is all ones, and the input ready is high.
- R10: Link-down high during a presented packet drops that packet; discontinue is low for exactly the next cycle, and the next packet starts at its first beat.
- R11: Input ready is low while either queue holds its full count of packets (4 by default). The sender starts a packet only while input ready is high and sends at most the configured maximum number of beats per packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input beat valid |
| in_sof | input | 1 | First beat of an input packet |
| in_eof | input | 1 | Last beat of an input packet |
| in_data | input | DATA_W | Input beat data |
| in_cls | input | 2 | Class code, sampled on the first beat |
| in_bar_hit | input | BAR_W | Window-hit vector, active high, sampled on the first beat |
| in_half | input | 1 | Last beat carries only the upper half, sampled on the end beat |
| in_poison | input | 1 | Packet is poisoned, sampled on the end beat |
| in_ready | output | 1 | A new packet may start |
| link_down | input | 1 | Link going into reset; aborts the presented packet |
| np_ok_n | input | 1 | Non-posted packets may be started, active low |
| rx_dst_rdy_n | input | 1 | User ready for a beat, active low |
| rx_sof_n | output | 1 | Start of frame, active low |
| rx_eof_n | output | 1 | End of frame, active low |
| rx_data | output | DATA_W | Output beat data |
| rx_rem_n | output | DATA_W/8 | Remainder on the end beat |
| rx_src_rdy_n | output | 1 | Beat presented, active low |
| rx_src_dsc_n | output | 1 | Packet aborted, active low |
| rx_err_fwd_n | output | 1 | Poisoned packet, on end beat, active low |
| rx_bar_hit_n | output | BAR_W | Window hits for the presented packet, active low |

## Verification
The bench builds the block with 4 packet slots per queue and a 4-beat packet limit. At that size both queues can be filled to capacity. It can check input ready exactly at the full boundary and sweep every packet length against every class and both remainder cases. Packets are loaded with the user stalled so that both queues hold mixed traffic. They are then drained with non-posted-ok in each state, and the arrival order computed in the bench fixes the expected service order. A mid-packet link-down checks the abort and the clean restart of the next packet.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  typedef enum logic [1:0] {
    CLS_POSTED     = 2'b00,
    CLS_NONPOSTED  = 2'b01,
    CLS_COMPLETION = 2'b10,
    CLS_RESERVED   = 2'b11
  } rxq_cls_e;

  localparam int Q_PC  = 0;
  localparam int Q_NP  = 1;
  localparam int NUM_Q = 2;

endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int DATA_W    = 64,
  parameter int PKTS      = 4,
  parameter int MAX_BEATS = 8,
  parameter int BAR_W     = 7,
  parameter int SEQ_W     = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_en,
  input  logic                         wr_sof,
  input  logic                         wr_eof,
  input  logic [DATA_W-1:0]            wr_data,
  input  logic                         wr_half,
  input  logic                         wr_poison,
  input  logic [BAR_W-1:0]             wr_bar,
  input  logic [SEQ_W-1:0]             wr_seq,
  input  logic                         pop,
  input  logic [$clog2(MAX_BEATS)-1:0] rd_beat,
  output logic                         head_valid,
  output logic                         full,
  output logic [$clog2(MAX_BEATS)-1:0] head_len,
  output logic                         head_half,
  output logic                         head_poison,
  output logic [BAR_W-1:0]             head_bar,
  output logic [SEQ_W-1:0]             head_seq,
  output logic [DATA_W-1:0]            rd_data
);
  localparam int BEAT_W = $clog2(MAX_BEATS);
  localparam int SLOT_W = (PKTS > 1) ? $clog2(PKTS) : 1;
  localparam int SLOTS  = 1 << SLOT_W;
  localparam int CNT_W  = $clog2(PKTS + 1);
  localparam int DEPTH  = SLOTS * (1 << BEAT_W);

  // Slot-organised data RAM: one fixed region of MAX_BEATS per packet.
  logic [DATA_W-1:0] mem [DEPTH];

  logic [SLOT_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0]  cnt;
  logic [BEAT_W-1:0] wr_beat;
  logic [BEAT_W-1:0] wr_col;
  logic [BAR_W-1:0]  pend_bar;
  logic [BAR_W-1:0]  bar_eff;
  logic              commit;

  logic [BEAT_W-1:0] d_len    [SLOTS];
  logic              d_half   [SLOTS];
  logic              d_poison [SLOTS];
  logic [BAR_W-1:0]  d_bar    [SLOTS];
  logic [SEQ_W-1:0]  d_seq    [SLOTS];

  function automatic logic [SLOT_W-1:0] slot_next(input logic [SLOT_W-1:0] p);
    return (p == SLOT_W'(PKTS - 1)) ? '0 : p + 1'b1;
  endfunction

  assign wr_col  = wr_sof ? '0 : wr_beat;
  assign bar_eff = wr_sof ? wr_bar : pend_bar;
  assign commit  = wr_en && wr_eof;

  always_ff @(posedge clk) begin
    if (wr_en) mem[{wr_ptr, wr_col}] <= wr_data;
  end

  always_ff @(posedge clk) begin
    rd_data <= mem[{rd_ptr, rd_beat}];
  end

  always_ff @(posedge clk) begin
    if (commit) begin
      d_len[wr_ptr]    <= wr_col;
      d_half[wr_ptr]   <= wr_half;
      d_poison[wr_ptr] <= wr_poison;
      d_bar[wr_ptr]    <= bar_eff;
      d_seq[wr_ptr]    <= wr_seq;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      cnt      <= '0;
      wr_beat  <= '0;
      pend_bar <= '0;
    end else begin
      if (wr_en) begin
        wr_beat <= wr_col + 1'b1;
        if (wr_sof) pend_bar <= wr_bar;
      end
      if (commit) wr_ptr <= slot_next(wr_ptr);
      if (pop)    rd_ptr <= slot_next(rd_ptr);
      cnt <= cnt + CNT_W'(commit) - CNT_W'(pop);
    end
  end

  assign head_valid  = (cnt != '0);
  assign full        = (cnt == CNT_W'(PKTS));
  assign head_len    = d_len[rd_ptr];
  assign head_half   = d_half[rd_ptr];
  assign head_poison = d_poison[rd_ptr];
  assign head_bar    = d_bar[rd_ptr];
  assign head_seq    = d_seq[rd_ptr];

  // R11: no packet may start into a queue that already holds PKTS packets.
  p_no_overflow_r11: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sof) |-> (cnt < CNT_W'(PKTS)));

  // R11: a continuation beat never wraps the per-packet beat region.
  p_beat_limit_r11: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_sof) |-> (wr_beat != '0));

  // R3: the reader only retires a committed packet.
  p_pop_nonempty_r3: assert property (@(posedge clk) disable iff (rst)
    pop |-> (cnt != '0));

endmodule

// File: rtl/rxq_arb.sv
module rxq_arb #(
  parameter int SEQ_W = 4
) (
  input  logic             hold,
  input  logic             np_ok,
  input  logic             np_valid,
  input  logic             pc_valid,
  input  logic [SEQ_W-1:0] np_seq,
  input  logic [SEQ_W-1:0] pc_seq,
  output logic             grant,
  output logic             grant_np
);
  logic [SEQ_W-1:0] age_diff;
  logic             np_older;

  // Stamps wrap; the window of live stamps is below half the range.
  assign age_diff = np_seq - pc_seq;
  assign np_older = age_diff[SEQ_W-1];

  always_comb begin
    grant_np = np_ok && np_valid && (!pc_valid || np_older);
    grant    = !hold && (grant_np || pc_valid);
  end

endmodule

// File: rtl/rxq_tx.sv
module rxq_tx #(
  parameter int DATA_W    = 64,
  parameter int MAX_BEATS = 8,
  parameter int BAR_W     = 7
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         grant,
  input  logic                         grant_np,
  input  logic [$clog2(MAX_BEATS)-1:0] cand_len,
  input  logic                         cand_half,
  input  logic                         cand_poison,
  input  logic [BAR_W-1:0]             cand_bar,
  input  logic                         link_down,
  input  logic                         dst_rdy_n,
  output logic [$clog2(MAX_BEATS)-1:0] rd_beat,
  output logic                         pop,
  output logic                         cur_np,
  output logic                         busy,
  output logic                         src_rdy_n,
  output logic                         sof_n,
  output logic                         eof_n,
  output logic [DATA_W/8-1:0]          rem_n,
  output logic                         err_n,
  output logic [BAR_W-1:0]             bar_n,
  output logic                         dsc_n
);
  localparam int BEAT_W = $clog2(MAX_BEATS);
  localparam int REM_W  = DATA_W / 8;
  localparam logic [REM_W-1:0] HALF_REM = {REM_W{1'b1}} >> (REM_W / 2);

  logic              sending;
  logic [BEAT_W-1:0] beat;
  logic [BEAT_W-1:0] len_q;
  logic              half_q, poison_q, dsc_q;
  logic [BAR_W-1:0]  bar_q;
  logic              xfer, abort, last;

  assign abort = sending && link_down;
  assign xfer  = sending && !dst_rdy_n && !link_down;
  assign last  = (beat == len_q);

  // Next read address is chosen combinationally so the registered RAM
  // output always holds the beat on the stream, with no bubble.
  always_comb begin
    if (!sending)  rd_beat = '0;
    else if (xfer) rd_beat = beat + 1'b1;
    else           rd_beat = beat;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sending  <= 1'b0;
      beat     <= '0;
      len_q    <= '0;
      half_q   <= 1'b0;
      poison_q <= 1'b0;
      bar_q    <= '0;
      cur_np   <= 1'b0;
      dsc_q    <= 1'b0;
    end else begin
      dsc_q <= abort;
      if (!sending) begin
        if (grant) begin
          sending  <= 1'b1;
          beat     <= '0;
          len_q    <= cand_len;
          half_q   <= cand_half;
          poison_q <= cand_poison;
          bar_q    <= cand_bar;
          cur_np   <= grant_np;
        end
      end else if (abort) begin
        sending <= 1'b0;
      end else if (xfer) begin
        if (last) sending <= 1'b0;
        else      beat    <= beat + 1'b1;
      end
    end
  end

  assign pop       = abort || (xfer && last);
  assign busy      = sending;
  assign src_rdy_n = !sending;
  assign sof_n     = !(sending && (beat == '0));
  assign eof_n     = !(sending && last);
  assign rem_n     = (sending && last && half_q) ? HALF_REM : '0;
  assign err_n     = !(sending && last && poison_q);
  assign bar_n     = sending ? ~bar_q : '1;
  assign dsc_n     = !dsc_q;

  // R2: a stalled beat stays on the stream unchanged.
  p_stall_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!src_rdy_n && dst_rdy_n && !link_down) |=>
      (!src_rdy_n && $stable(beat) && $stable(sof_n) && $stable(eof_n)));

  // R7: the poison marker appears only on an end beat.
  p_err_on_eof_r7: assert property (@(posedge clk) disable iff (rst)
    !err_n |-> !eof_n);

  // R10: the discontinue strobe is a single-cycle pulse.
  p_dsc_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    !dsc_n |=> dsc_n);

endmodule

// File: rtl/rxq_np_bypass.sv
module rxq_np_bypass #(
  parameter int DATA_W    = 64,
  parameter int PKTS      = 4,
  parameter int MAX_BEATS = 8,
  parameter int BAR_W     = 7
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic                in_sof,
  input  logic                in_eof,
  input  logic [DATA_W-1:0]   in_data,
  input  logic [1:0]          in_cls,
  input  logic [BAR_W-1:0]    in_bar_hit,
  input  logic                in_half,
  input  logic                in_poison,
  output logic                in_ready,
  input  logic                link_down,
  input  logic                np_ok_n,
  input  logic                rx_dst_rdy_n,
  output logic                rx_sof_n,
  output logic                rx_eof_n,
  output logic [DATA_W-1:0]   rx_data,
  output logic [DATA_W/8-1:0] rx_rem_n,
  output logic                rx_src_rdy_n,
  output logic                rx_src_dsc_n,
  output logic                rx_err_fwd_n,
  output logic [BAR_W-1:0]    rx_bar_hit_n
);
  import rxq_pkg::*;

  localparam int BEAT_W = $clog2(MAX_BEATS);
  localparam int SEQ_W  = $clog2(2 * PKTS) + 1;

  logic                         route_np, cur_in_np;
  logic [SEQ_W-1:0]             seq_q;
  logic [NUM_Q-1:0]             q_valid, q_full, q_half, q_poison, q_pop;
  logic [NUM_Q-1:0][BEAT_W-1:0] q_len;
  logic [NUM_Q-1:0][BAR_W-1:0]  q_bar;
  logic [NUM_Q-1:0][SEQ_W-1:0]  q_seq;
  logic [NUM_Q-1:0][DATA_W-1:0] q_rd;
  logic [BEAT_W-1:0]            rd_beat;
  logic                         grant, grant_np;
  logic                         tx_pop, tx_cur_np, tx_busy;

  assign route_np = in_sof ? (in_cls == CLS_NONPOSTED) : cur_in_np;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_in_np <= 1'b0;
      seq_q     <= '0;
    end else if (in_valid) begin
      cur_in_np <= route_np;
      if (in_eof) seq_q <= seq_q + 1'b1;
    end
  end

  for (genvar g = 0; g < NUM_Q; g++) begin : g_queue
    localparam logic IS_NP = (g == Q_NP);
    assign q_pop[g] = tx_pop && (tx_cur_np == IS_NP);

    rxq_store #(
      .DATA_W(DATA_W), .PKTS(PKTS), .MAX_BEATS(MAX_BEATS),
      .BAR_W(BAR_W), .SEQ_W(SEQ_W)
    ) u_store (
      .clk         (clk),
      .rst         (rst),
      .wr_en       (in_valid && (route_np == IS_NP)),
      .wr_sof      (in_sof),
      .wr_eof      (in_eof),
      .wr_data     (in_data),
      .wr_half     (in_half),
      .wr_poison   (in_poison),
      .wr_bar      (in_bar_hit),
      .wr_seq      (seq_q),
      .pop         (q_pop[g]),
      .rd_beat     (rd_beat),
      .head_valid  (q_valid[g]),
      .full        (q_full[g]),
      .head_len    (q_len[g]),
      .head_half   (q_half[g]),
      .head_poison (q_poison[g]),
      .head_bar    (q_bar[g]),
      .head_seq    (q_seq[g]),
      .rd_data     (q_rd[g])
    );
  end

  assign in_ready = !(|q_full);

  rxq_arb #(.SEQ_W(SEQ_W)) u_arb (
    .hold     (tx_busy || link_down),
    .np_ok    (!np_ok_n),
    .np_valid (q_valid[Q_NP]),
    .pc_valid (q_valid[Q_PC]),
    .np_seq   (q_seq[Q_NP]),
    .pc_seq   (q_seq[Q_PC]),
    .grant    (grant),
    .grant_np (grant_np)
  );

  rxq_tx #(.DATA_W(DATA_W), .MAX_BEATS(MAX_BEATS), .BAR_W(BAR_W)) u_tx (
    .clk         (clk),
    .rst         (rst),
    .grant       (grant),
    .grant_np    (grant_np),
    .cand_len    (grant_np ? q_len[Q_NP]    : q_len[Q_PC]),
    .cand_half   (grant_np ? q_half[Q_NP]   : q_half[Q_PC]),
    .cand_poison (grant_np ? q_poison[Q_NP] : q_poison[Q_PC]),
    .cand_bar    (grant_np ? q_bar[Q_NP]    : q_bar[Q_PC]),
    .link_down   (link_down),
    .dst_rdy_n   (rx_dst_rdy_n),
    .rd_beat     (rd_beat),
    .pop         (tx_pop),
    .cur_np      (tx_cur_np),
    .busy        (tx_busy),
    .src_rdy_n   (rx_src_rdy_n),
    .sof_n       (rx_sof_n),
    .eof_n       (rx_eof_n),
    .rem_n       (rx_rem_n),
    .err_n       (rx_err_fwd_n),
    .bar_n       (rx_bar_hit_n),
    .dsc_n       (rx_src_dsc_n)
  );

  assign rx_data = tx_cur_np ? q_rd[Q_NP] : q_rd[Q_PC];

  // R1: a packet always opens with start-of-frame.
  p_sof_ready_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rx_src_rdy_n) |-> !rx_sof_n);

  // R5: a packet opened while non-posted-ok was high is never non-posted.
  p_np_gate_r5: assert property (@(posedge clk) disable iff (rst)
    ($fell(rx_src_rdy_n) && $past(np_ok_n)) |-> !tx_cur_np);

  // R11: the sender honours input ready at packet start.
  p_start_ready_r11: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_sof) |-> in_ready);

endmodule

// File: tb/rxq_np_bypass_bench.sv
module rxq_np_bypass_bench;
  localparam int DW = 64;
  localparam int PK = 4;
  localparam int MB = 4;
  localparam int BW = 7;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst = 1'b1;
  logic          in_valid = 0, in_sof = 0, in_eof = 0, in_half = 0, in_poison = 0;
  logic [DW-1:0] in_data = '0;
  logic [1:0]    in_cls = '0;
  logic [BW-1:0] in_bar_hit = '0;
  logic          in_ready;
  logic          link_down = 0, np_ok_n = 0, rx_dst_rdy_n = 1;
  logic          rx_sof_n, rx_eof_n, rx_src_rdy_n, rx_src_dsc_n, rx_err_fwd_n;
  logic [DW-1:0] rx_data;
  logic [7:0]    rx_rem_n;
  logic [BW-1:0] rx_bar_hit_n;

  rxq_np_bypass #(.DATA_W(DW), .PKTS(PK), .MAX_BEATS(MB), .BAR_W(BW)) u_rxq_np_bypass (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof),
    .in_data(in_data), .in_cls(in_cls), .in_bar_hit(in_bar_hit), .in_half(in_half),
    .in_poison(in_poison), .in_ready(in_ready), .link_down(link_down), .np_ok_n(np_ok_n),
    .rx_dst_rdy_n(rx_dst_rdy_n), .rx_sof_n(rx_sof_n), .rx_eof_n(rx_eof_n), .rx_data(rx_data),
    .rx_rem_n(rx_rem_n), .rx_src_rdy_n(rx_src_rdy_n), .rx_src_dsc_n(rx_src_dsc_n),
    .rx_err_fwd_n(rx_err_fwd_n), .rx_bar_hit_n(rx_bar_hit_n)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;
  int          a_len  [64];
  bit          a_half [64];
  bit          a_pois [64];
  logic [6:0]  a_bar  [64];

  function automatic logic [63:0] pat(int id, int b);
    return {8'(id), 8'(b), 8'(id) ^ 8'h5A, 8'(b + 3), 32'(id * 1000 + b * 17 + 5)};
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic send_pkt(int id, logic [1:0] cls, int len, bit half, logic [6:0] bar, bit pois);
    a_len[id] = len; a_half[id] = half; a_bar[id] = bar; a_pois[id] = pois;
    for (int b = 0; b < len; b++) begin
      @(negedge clk);
      in_valid = 1; in_sof = (b == 0); in_eof = (b == len - 1);
      in_data = pat(id, b); in_cls = cls; in_bar_hit = bar;
      in_half = half; in_poison = pois;
    end
    @(negedge clk);
    in_valid = 0; in_sof = 0; in_eof = 0;
  endtask

  task automatic recv_pkt(int id, int stall);
    int b = 0;
    int cyc = 0;
    bit done = 0;
    bit was_stall = 0;
    logic [63:0] held = '0;
    while (!done && cyc < 300) begin
      @(negedge clk);
      rx_dst_rdy_n = (stall != 0) && (cyc % 2 == 0);
      cyc++;
      #1;
      if (was_stall)
        chk(!rx_src_rdy_n && rx_data == held, "R2 beat held while stalled", rx_data, held);
      was_stall = !rx_src_rdy_n && rx_dst_rdy_n;
      held = rx_data;
      if (!rx_src_rdy_n && !rx_dst_rdy_n) begin
        bit last;
        last = (b == a_len[id] - 1);
        chk(rx_data == pat(id, b), "R3 R4 data and service order", rx_data, pat(id, b));
        chk(rx_sof_n == (b != 0), "R1 start-of-frame position", 64'(rx_sof_n), 64'(b != 0));
        chk(rx_eof_n == !last, "R2 end-of-frame position", 64'(rx_eof_n), 64'(!last));
        chk(rx_rem_n == ((last && a_half[id]) ? 8'h0F : 8'h00), "R6 remainder",
            64'(rx_rem_n), 64'((last && a_half[id]) ? 8'h0F : 8'h00));
        chk(rx_err_fwd_n == !(last && a_pois[id]), "R7 error forward",
            64'(rx_err_fwd_n), 64'(!(last && a_pois[id])));
        chk(rx_bar_hit_n == ~a_bar[id], "R8 window hits", 64'(rx_bar_hit_n), 64'(~a_bar[id]));
        b++;
        done = last;
      end
    end
    if (!done) chk(0, "R9 packet not delivered", 64'(b), 64'(id));
    @(negedge clk);
    rx_dst_rdy_n = 1;
  endtask

  task automatic idle_chk(int n, string req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
      chk(rx_src_rdy_n == 1'b1, req, 64'(rx_src_rdy_n), 64'd1);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog R9 actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk); #1;
    // R9: idle state after reset
    chk(rx_src_rdy_n && rx_sof_n && rx_eof_n && rx_src_dsc_n && rx_err_fwd_n,
        "R9 reset framing idle",
        64'({rx_src_rdy_n, rx_sof_n, rx_eof_n, rx_src_dsc_n, rx_err_fwd_n}), 64'h1F);
    chk(rx_bar_hit_n == 7'h7F, "R9 reset window hits", 64'(rx_bar_hit_n), 64'h7F);
    chk(in_ready == 1'b1, "R9 reset input ready", 64'(in_ready), 64'd1);

    // R1: nothing presented until the end beat has been written
    np_ok_n = 0;
    rx_dst_rdy_n = 0;
    send_pkt(0, 2'b00, 3, 0, 7'b0000001, 0);
    #1 chk(rx_src_rdy_n == 1'b1, "R1 held back until stored", 64'(rx_src_rdy_n), 64'd1);
    rx_dst_rdy_n = 1;
    recv_pkt(0, 0);

    // R4: mixed load, served by arrival order with non-posted-ok asserted
    send_pkt(1, 2'b00, 4, 1, 7'b0000110, 0);
    send_pkt(2, 2'b01, 1, 0, 7'b1000000, 1);
    send_pkt(3, 2'b10, 2, 1, 7'b0000000, 0);
    send_pkt(4, 2'b01, 4, 0, 7'b0100000, 0);
    send_pkt(5, 2'b11, 2, 0, 7'b0001000, 1);
    recv_pkt(1, 1);
    recv_pkt(2, 0);
    recv_pkt(3, 1);
    recv_pkt(4, 0);
    recv_pkt(5, 1);
    idle_chk(3, "R9 idle after drain");

    // R5: gate closed, posted and completion overtake requests
    np_ok_n = 1;
    send_pkt(6, 2'b01, 2, 0, 7'b0000010, 0);
    send_pkt(7, 2'b01, 3, 1, 7'b0010000, 0);
    send_pkt(8, 2'b00, 1, 1, 7'b0000100, 0);
    send_pkt(9, 2'b10, 4, 0, 7'b0011000, 1);
    recv_pkt(8, 0);
    recv_pkt(9, 1);
    idle_chk(12, "R5 requests held while gate closed");
    np_ok_n = 0;
    recv_pkt(6, 0);
    recv_pkt(7, 1);

    // R11: capacity boundary of the request queue, R3 order kept
    np_ok_n = 1;
    send_pkt(10, 2'b01, 1, 0, 7'b0000001, 0);
    send_pkt(11, 2'b01, 2, 1, 7'b0000010, 0);
    send_pkt(12, 2'b01, 3, 0, 7'b0000100, 1);
    #1 chk(in_ready == 1'b1, "R11 ready below capacity", 64'(in_ready), 64'd1);
    send_pkt(13, 2'b01, 4, 1, 7'b0001000, 0);
    #1 chk(in_ready == 1'b0, "R11 not ready at capacity", 64'(in_ready), 64'd0);
    np_ok_n = 0;
    recv_pkt(10, 0);
    #1 chk(in_ready == 1'b1, "R11 ready after one leaves", 64'(in_ready), 64'd1);
    recv_pkt(11, 1);
    recv_pkt(12, 0);
    recv_pkt(13, 1);

    // R10: link-down in the middle of a packet
    send_pkt(14, 2'b00, 4, 0, 7'b0100001, 0);
    send_pkt(15, 2'b10, 2, 1, 7'b1000010, 1);
    a_len[14] = 4;
    @(negedge clk);
    rx_dst_rdy_n = 0;
    #1 chk(!rx_src_rdy_n && !rx_sof_n && rx_data == pat(14, 0), "R10 first beat before abort",
           rx_data, pat(14, 0));
    @(negedge clk);
    rx_dst_rdy_n = 1;
    link_down = 1;
    @(negedge clk); #1;
    chk(rx_src_dsc_n == 1'b0, "R10 discontinue pulse", 64'(rx_src_dsc_n), 64'd0);
    chk(rx_src_rdy_n == 1'b1, "R10 stream dropped", 64'(rx_src_rdy_n), 64'd1);
    link_down = 0;
    @(negedge clk); #1;
    chk(rx_src_dsc_n == 1'b1, "R10 discontinue single cycle", 64'(rx_src_dsc_n), 64'd1);
    recv_pkt(15, 0);

    // Sweep: every length, both remainder cases, every class code
    for (int len = 1; len <= MB; len++) begin
      for (int h = 0; h < 2; h++) begin
        for (int c = 0; c < 4; c++) begin
          int id;
          id = 16 + (len - 1) * 8 + h * 4 + c;
          send_pkt(id, 2'(c), len, h[0], 7'(1 << ((id + c) % 7)), ((id % 3) == 0));
          recv_pkt(id, len % 2);
        end
      end
    end
    idle_chk(2, "R9 idle at end");
    finish_run();
  end

endmodule